// File: doc/BRIEF.md
# Debounced Push-Button Up/Down Counter

This block counts physical presses of a mechanical push-button. The raw button level is not a clock. It comes into the block's clock domain through a two-stage synchronizer and is then shifted into a short history register once every clock. The 4-bit count moves by one only when that history shows a single old low sample followed by a run of high samples. Because of this, contact bounce, short glitches and a button held down each produce no more than one step.

A second input selects the direction. It passes through the same synchronizer as the button, so the two stay aligned in time. The direction value that the synchronizer holds in the cycle the step fires decides whether the count goes up or down. The count wraps in both directions. A synchronous reset returns the count to zero. Reset also presets the history so that a button already held during reset is not counted.

Top module: `press_counter`

## Requirements
- R1: While the synchronous reset `rst_i` is high, and on the first clock after it is released, `count_o` reads 0.
- R2: The history register holds the last 5 synchronized button samples, with the newest at bit 0. A step fires only when the history equals 5'b01111, that is, the oldest sample is low and the four newest samples are high. A press that is high for 4 or more clocks counts once. A press that is high for 3 clocks or fewer does not count.
- R3: When a step fires and the synchronized direction is 1, `count_o` increases by one.
- R4: When a step fires and the synchronized direction is 0, `count_o` decreases by one.
- R5: The count wraps modulo 16: 15 steps up to 0, and 0 steps down to 15.
- R6: Holding the button high for any length of time gives exactly one step. No further step fires until the button has gone low and high again.
- R7: Bounce, meaning high pulses shorter than 4 clocks mixed with low gaps, gives no step until the level stays high for 4 clocks, and then exactly one step.
- R8: Both inputs pass through a two-flop synchronizer. When `btn_i` rises in front of clock edge 1 after a long low period, `count_o` is unchanged after edge 6 and updated after edge 7.
- R9: Reset presets the synchronizer's button stage and the history to all ones. A button held high through reset and after it gives no step until it is released and pressed again.
- R10: The direction used is the synchronized value in the step cycle. Changes of `dir_i` while no step fires, including while the button is held after its step, leave `count_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Raw push-button level, asynchronous to the clock |
| dir_i | input | 1 | Count direction: 1 counts up, 0 counts down |
| count_o | output | 4 | Current count value |

## Verification
The bench builds the block with its default parameters: a 4-bit count, a 5-sample history and two synchronizer stages. With these values the wrap points at 0 and 15 are only a few presses away. The 4-clock minimum press, the 7-clock latency from button to count and the bounce patterns can all be timed exactly in clock cycles. These defaults also make the 3-clock rejection and the held-through-reset case cheap to reach.

// File: rtl/press_counter_pkg.sv
package press_counter_pkg;
  localparam int unsigned DEF_CNT_W   = 4;
  localparam int unsigned DEF_HIST_W  = 5;
  localparam int unsigned DEF_SYNC_N  = 2;
  // lane positions inside the synchronizer bundle
  localparam int unsigned LANE_BTN    = 0;
  localparam int unsigned LANE_DIR    = 1;
  localparam int unsigned LANES       = 2;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < int'(STAGES); s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pc_press_detect.sv
module pc_press_detect #(
  parameter int unsigned HIST_W = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic step_o
);
  // the oldest sample is low and every newer sample is high
  localparam logic [HIST_W-1:0] MATCH = {1'b0, {(HIST_W-1){1'b1}}};

  logic [HIST_W-1:0] hist;

  always_ff @(posedge clk_i) begin
    if (rst_i) hist <= '1;
    else       hist <= {hist[HIST_W-2:0], lvl_i};
  end

  assign step_o = (hist == MATCH);
endmodule

// File: rtl/pc_updown.sv
module pc_updown
  import press_counter_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             step_i,
  input  dir_e             dir_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (step_i) cnt_q <= (dir_i == DIR_UP) ? cnt_q + ONE : cnt_q - ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/press_counter.sv
module press_counter
  import press_counter_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned HIST_W = DEF_HIST_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             btn_i,
  input  logic             dir_i,
  output logic [CNT_W-1:0] count_o
);
  // the button lane resets high so that a press held through reset does not count
  localparam logic [LANES-1:0] SYNC_RST = LANES'(1) << LANE_BTN;

  logic [LANES-1:0] raw_w, syn_w;
  logic             step_w;
  logic             btn_s;
  dir_e             dir_s;

  assign raw_w[LANE_BTN] = btn_i;
  assign raw_w[LANE_DIR] = dir_i;

  pc_sync #(.WIDTH(LANES), .STAGES(SYNC_N), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_w),
    .q_o   (syn_w)
  );

  assign btn_s = syn_w[LANE_BTN];
  assign dir_s = dir_e'(syn_w[LANE_DIR]);

  pc_press_detect #(.HIST_W(HIST_W)) u_detect (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  (btn_s),
    .step_o (step_w)
  );

  pc_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (step_w),
    .dir_i  (dir_s),
    .cnt_o  (count_o)
  );
endmodule

// File: rtl/press_counter_chk.sv
module press_counter_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [CNT_W-1:0] count_o,
  input logic             step,
  input logic             dir_s
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R1
  p_reset_zero_r1: assert property (@(posedge clk_i) rst_i |=> count_o == '0);

  // R3
  p_step_up_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (step && dir_s) |=> count_o == CNT_W'($past(count_o) + ONE));

  // R4
  p_step_down_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (step && !dir_s) |=> count_o == CNT_W'($past(count_o) - ONE));

  // R10
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !step |=> $stable(count_o));

  // R6
  p_single_step_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    step |=> !step);
endmodule

bind press_counter press_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .count_o (count_o),
  .step    (step_w),
  .dir_s   (dir_s)
);

// File: tb/tb_press_counter.sv
module tb_press_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn = 1'b0;
  logic       dir = 1'b1;
  logic [3:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  press_counter dut (
    .clk_i   (clk),
    .rst_i   (rst),
    .btn_i   (btn),
    .dir_i   (dir),
    .count_o (count)
  );

  // columns: direction, high cycles, expected count after the press
  localparam int NV = 10;
  localparam bit       V_DIR [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 1};
  localparam int       V_HOLD[NV] = '{6, 4, 3, 30, 5, 2, 4, 7, 5, 4};
  localparam logic [3:0] V_EXP[NV] = '{4'd1, 4'd2, 4'd2, 4'd3, 4'd2,
                                       4'd2, 4'd1, 4'd0, 4'd15, 4'd0};

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(bit d, int hold);
    dir = d;
    btn = 1'b1;
    tick(hold);
    btn = 1'b0;
    tick(12);
  endtask

  initial begin
    logic [3:0] base;
    tick(3);
    check("R1 reset value", count, 4'd0);
    rst = 1'b0;
    tick(1);
    check("R1 first cycle after reset", count, 4'd0);
    tick(10);

    // table: R2 length threshold, R3 up, R4 down, R5 wrap, R6 held
    for (int v = 0; v < NV; v++) begin
      press(V_DIR[v], V_HOLD[v]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", v), count, V_EXP[v]);
    end

    // R8 latency from button edge to count
    base = count;
    dir = 1'b1;
    btn = 1'b1;
    tick(6);
    check("R8 unchanged after edge 6", count, base);
    tick(1);
    check("R8 updated after edge 7", count, 4'(base + 4'd1));
    btn = 1'b0;
    tick(12);

    // R7 bounce on press and on release
    base = count;
    btn = 1'b1; tick(2); btn = 1'b0; tick(1);
    btn = 1'b1; tick(1); btn = 1'b0; tick(2);
    btn = 1'b1; tick(3);
    check("R7 no step during bounce", count, base);
    tick(6);
    btn = 1'b0; tick(1); btn = 1'b1; tick(1); btn = 1'b0; tick(2);
    btn = 1'b1; tick(2); btn = 1'b0; tick(12);
    check("R7 one step for bouncy press", count, 4'(base + 4'd1));

    // R10 direction toggles alone
    base = count;
    for (int k = 0; k < 6; k++) begin dir = ~dir; tick(3); end
    check("R10 direction alone no effect", count, base);

    // R10 direction changed while held after the step
    dir = 1'b1;
    btn = 1'b1;
    tick(10);
    dir = 1'b0;
    tick(15);
    btn = 1'b0;
    tick(12);
    check("R10 late direction change ignored", count, 4'(base + 4'd1));

    // R9 button held through reset
    rst = 1'b1;
    btn = 1'b1;
    dir = 1'b1;
    tick(4);
    check("R1 reset clears count", count, 4'd0);
    rst = 1'b0;
    tick(20);
    check("R9 held through reset no step", count, 4'd0);
    btn = 1'b0;
    tick(12);
    check("R9 release after reset no step", count, 4'd0);
    press(1'b1, 5);
    check("R9 fresh press counts", count, 4'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: count=%0d expected=finished", count);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule